// File: doc/BRIEF.md
# Duty Ramp Engine for a PWM Channel

This block moves a PWM channel's 25-bit duty word toward a new level in small equal steps, with no software involvement once a ramp is launched. Software gives a step size, how many PWM periods pass between steps, how many steps to take, and whether the duty climbs or falls. It then writes the settings together with a start flag. The engine holds the live duty word that the channel's comparator reads. The same word is visible on an output at all times. When the final step lands, the engine emits a one-cycle completion pulse.

The comparator and the period timers sit outside this block. The engine only sees a one-cycle `period_tick` pulse per PWM period. Software may load the duty word directly at any time. The start flag is cleared by the hardware itself one cycle after it is written, and that is the cycle in which the ramp takes over. If a new start arrives during a ramp, the ramp begins again from the present duty with the new settings.

Top module: `duty_ramp_top`

## Requirements
- R1: After reset, `duty_level` is 0 and `start_pending`, `ramp_active` and `fade_done` are all 0.
- R2: A cycle with `duty_wr` high makes `duty_level` equal to `duty_wdata` after that clock edge.
- R3: A cycle with `cfg_wr` and `cfg_start` both high captures the step settings and raises `start_pending` after that edge. The hardware drops `start_pending` one edge later, and the ramp becomes active at that same edge.
- R4: A cycle with `cfg_wr` high and `cfg_start` low changes nothing visible: `duty_level`, `start_pending` and `ramp_active` keep their values.
- R5: Each step adds `cfg_scale` to the duty when `cfg_up` is 1 and subtracts it when `cfg_up` is 0.
- R6: While a ramp is active, one step is applied on every `cfg_interval`-th `period_tick`, counted from the start of the ramp. The step lands at the edge that samples that tick. A `cfg_interval` of 0 behaves as 1.
- R7: A ramp applies exactly `cfg_count` steps. `fade_done` is high for one cycle after the edge that applies the last step, and `ramp_active` falls at that same edge.
- R8: A rising duty stops at 2^25-1 and a falling duty stops at 0. Steps that are clipped still count toward `cfg_count`.
- R9: A start with `cfg_count` equal to 0 leaves the duty unchanged. It never makes the ramp active, and it raises `fade_done` for one cycle at the edge where the start flag clears.
- R10: A start during an active ramp abandons that ramp. A new ramp begins from the present duty with the newly captured settings.
- R11: When no ramp is active, `period_tick` has no effect on `duty_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse per PWM period |
| duty_wr | input | 1 | Load `duty_wdata` into the duty word |
| duty_wdata | input | 25 | Direct duty value |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_start | input | 1 | Start flag accompanying `cfg_wr` |
| cfg_scale | input | 10 | Duty change per step |
| cfg_interval | input | 10 | Periods between steps (0 acts as 1) |
| cfg_count | input | 10 | Number of steps |
| cfg_up | input | 1 | 1 = increase duty, 0 = decrease |
| duty_level | output | 25 | Live duty word |
| start_pending | output | 1 | Readable start flag, cleared by hardware |
| ramp_active | output | 1 | Ramp in progress |
| fade_done | output | 1 | One-cycle completion pulse |

## Verification
A direct duty load shows one edge after the write cycle. A start shows `start_pending` one edge after the write, and the flag clears, the ramp activates and a zero-count done pulse all appear one edge later again. A step, and the done pulse that comes with the final step, shows one edge after the cycle carrying `period_tick`. The bench therefore drives each stimulus for exactly one cycle from a falling edge and samples at the next falling edge. It compares against a per-ramp expectation computed from the tick count, the effective interval and a saturating step function. Idle gaps between ticks are checked to show the duty holding still.

// File: rtl/fade_pkg.sv
package fade_pkg;

    localparam int DUTY_W = 25;
    localparam int FLD_W  = 10;

    typedef logic [DUTY_W-1:0] duty_t;
    typedef logic [FLD_W-1:0]  fld_t;

    typedef struct packed {
        fld_t scale;
        fld_t interval;
        fld_t count;
        logic up;
    } ramp_cfg_t;

    // Effective number of periods between steps: zero is read as one.
    function automatic fld_t eff_interval(input fld_t iv);
        fld_t r;
        r = (iv == '0) ? fld_t'(1) : iv;
        return r;
    endfunction

    // One saturating step of the duty word.
    function automatic duty_t sat_step(input duty_t d, input fld_t s, input logic up);
        logic [DUTY_W:0] wide;
        duty_t           r;
        duty_t           s_ext;
        s_ext = duty_t'(s);
        if (up) begin
            wide = {1'b0, d} + {1'b0, s_ext};
            r    = wide[DUTY_W] ? '1 : wide[DUTY_W-1:0];
        end else begin
            r = (s_ext > d) ? '0 : (d - s_ext);
        end
        return r;
    endfunction

endpackage

// File: rtl/ramp_cfg_latch.sv
module ramp_cfg_latch
    import fade_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  logic      cfg_start,
    input  ramp_cfg_t cfg_in,
    output ramp_cfg_t cfg_q,
    output logic      pending
);

    // Settings are captured only together with the start flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            pending <= 1'b0;
        end else if (cfg_wr && cfg_start) begin
            cfg_q   <= cfg_in;
            pending <= 1'b1;
        end else begin
            pending <= 1'b0;
        end
    end

    AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (pending && !(cfg_wr && cfg_start)) |=> !pending); // R3

    AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_start) |=> $stable(cfg_q)); // R4

endmodule

// File: rtl/ramp_pacer.sv
module ramp_pacer
    import fade_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic active,
    input  logic tick,
    input  fld_t interval,
    output logic step_en
);

    fld_t cnt;
    fld_t eff;

    always_comb begin
        eff     = eff_interval(interval);
        step_en = active && tick && !arm && (cnt == eff - fld_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            cnt <= '0;
        end else if (active && tick) begin
            cnt <= step_en ? '0 : cnt + fld_t'(1);
        end
    end

    AST_PACE_BELOW_INTERVAL: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt < eff)); // R6

endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
    import fade_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      arm,
    input  ramp_cfg_t cfg,
    input  logic      step_en,
    input  logic      load,
    input  duty_t     load_val,
    output duty_t     duty,
    output logic      active,
    output logic      done
);

    fld_t rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                rem    <= cfg.count;
                active <= (cfg.count != '0);
                done   <= (cfg.count == '0);
            end else if (step_en) begin
                rem <= rem - fld_t'(1);
                if (rem == fld_t'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty <= '0;
        end else if (load) begin
            duty <= load_val;
        end else if (step_en) begin
            duty <= sat_step(duty, cfg.scale, cfg.up);
        end
    end

    AST_DONE_ENDS_RAMP: assert property (@(posedge clk) disable iff (rst)
        done |-> !active); // R7

    AST_IDLE_HOLDS_DUTY: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> $stable(duty)); // R11

    AST_UP_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_en && cfg.up && !load) |=> (duty >= $past(duty))); // R8

    AST_DOWN_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_en && !cfg.up && !load) |=> (duty <= $past(duty))); // R8

endmodule

// File: rtl/duty_ramp_top.sv
module duty_ramp_top
    import fade_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              period_tick,
    input  logic              duty_wr,
    input  logic [DUTY_W-1:0] duty_wdata,
    input  logic              cfg_wr,
    input  logic              cfg_start,
    input  logic [FLD_W-1:0]  cfg_scale,
    input  logic [FLD_W-1:0]  cfg_interval,
    input  logic [FLD_W-1:0]  cfg_count,
    input  logic              cfg_up,
    output logic [DUTY_W-1:0] duty_level,
    output logic              start_pending,
    output logic              ramp_active,
    output logic              fade_done
);

    ramp_cfg_t cfg_in;
    ramp_cfg_t cfg_q;
    logic      step_en;

    always_comb begin
        cfg_in.scale    = cfg_scale;
        cfg_in.interval = cfg_interval;
        cfg_in.count    = cfg_count;
        cfg_in.up       = cfg_up;
    end

    ramp_cfg_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_start (cfg_start),
        .cfg_in    (cfg_in),
        .cfg_q     (cfg_q),
        .pending   (start_pending)
    );

    ramp_pacer u_pacer (
        .clk      (clk),
        .rst      (rst),
        .arm      (start_pending),
        .active   (ramp_active),
        .tick     (period_tick),
        .interval (cfg_q.interval),
        .step_en  (step_en)
    );

    ramp_stepper u_stepper (
        .clk      (clk),
        .rst      (rst),
        .arm      (start_pending),
        .cfg      (cfg_q),
        .step_en  (step_en),
        .load     (duty_wr),
        .load_val (duty_wdata),
        .duty     (duty_level),
        .active   (ramp_active),
        .done     (fade_done)
    );

    AST_TICK_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        (!ramp_active && !start_pending) |=> !fade_done); // R11

endmodule

// File: tb/sim_duty_ramp_top.sv
module sim_duty_ramp_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [24:0] DMAX = 25'h1FF_FFFF;

    logic        clk = 1'b0;
    logic        rst;
    logic        period_tick;
    logic        duty_wr;
    logic [24:0] duty_wdata;
    logic        cfg_wr;
    logic        cfg_start;
    logic [9:0]  cfg_scale;
    logic [9:0]  cfg_interval;
    logic [9:0]  cfg_count;
    logic        cfg_up;
    logic [24:0] duty_level;
    logic        start_pending;
    logic        ramp_active;
    logic        fade_done;

    int checks = 0;
    int errors = 0;

    // Expectation state for the ramp in flight.
    logic [24:0] b_base;
    logic [9:0]  b_scale;
    logic        b_up;
    int          b_int;
    int          b_cnt;
    int          b_ticks;
    bit          b_live;

    always #(CLK_PERIOD/2) clk = ~clk;

    duty_ramp_top u0 (
        .clk(clk), .rst(rst), .period_tick(period_tick),
        .duty_wr(duty_wr), .duty_wdata(duty_wdata),
        .cfg_wr(cfg_wr), .cfg_start(cfg_start),
        .cfg_scale(cfg_scale), .cfg_interval(cfg_interval),
        .cfg_count(cfg_count), .cfg_up(cfg_up),
        .duty_level(duty_level), .start_pending(start_pending),
        .ramp_active(ramp_active), .fade_done(fade_done)
    );

    function automatic logic [24:0] model_duty(input logic [24:0] d, input logic [9:0] s,
                                               input logic up, input int n);
        longint v;
        v = d;
        for (int i = 0; i < n; i++) begin
            if (up) v = (v + s > 64'(DMAX)) ? 64'(DMAX) : v + s;
            else    v = (s > v) ? 0 : v - s;
        end
        return v[24:0];
    endfunction

    function automatic int steps_taken();
        int n;
        if (!b_live) return 0;
        n = b_ticks / b_int;
        return (n > b_cnt) ? b_cnt : n;
    endfunction

    function automatic logic [24:0] exp_duty();
        return model_duty(b_base, b_scale, b_up, steps_taken());
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load_duty(input logic [24:0] v);
        duty_wr = 1'b1; duty_wdata = v;
        @(negedge clk);
        duty_wr = 1'b0;
        check("R2 duty load", duty_level, v);
        b_base = v; b_live = 0; b_ticks = 0;
    endtask

    task automatic launch(input logic [9:0] s, input logic [9:0] iv, input logic [9:0] n, input logic up);
        logic [24:0] cur;
        cur = exp_duty();
        cfg_wr = 1'b1; cfg_start = 1'b1;
        cfg_scale = s; cfg_interval = iv; cfg_count = n; cfg_up = up;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_start = 1'b0;
        check("R3 start flag set", start_pending, 1);
        @(negedge clk);
        check("R3 start flag self-clears", start_pending, 0);
        check("R3 ramp active on arm", ramp_active, (n != 0));
        check("R9 done at arm for zero count", fade_done, (n == 0));
        check("R10 duty kept across start", duty_level, cur);
        b_base = cur; b_scale = s; b_up = up;
        b_int = (iv == 0) ? 1 : int'(iv);
        b_cnt = n; b_ticks = 0; b_live = 1;
    endtask

    task automatic one_tick(input int gap);
        period_tick = 1'b1;
        @(negedge clk);
        period_tick = 1'b0;
        if (b_live) b_ticks++;
        check("R5 R6 R8 duty after tick", duty_level, exp_duty());
        check("R7 done timing", fade_done, (b_live && b_cnt != 0 && b_ticks == b_cnt * b_int));
        check("R7 active level", ramp_active, (b_live && b_ticks < b_cnt * b_int));
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check("R6 no step without tick", duty_level, exp_duty());
        end
    endtask

    task automatic run_all(input int gap);
        int total;
        total = b_cnt * b_int + 1;
        for (int k = 0; k < total; k++) one_tick(gap);
    endtask

    initial begin
        rst = 1'b1; period_tick = 0; duty_wr = 0; duty_wdata = '0;
        cfg_wr = 0; cfg_start = 0; cfg_scale = '0; cfg_interval = '0; cfg_count = '0; cfg_up = 0;
        b_base = '0; b_scale = '0; b_up = 0; b_int = 1; b_cnt = 0; b_ticks = 0; b_live = 0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset duty", duty_level, 0);
        check("R1 reset start flag", start_pending, 0);
        check("R1 reset active", ramp_active, 0);
        check("R1 reset done", fade_done, 0);

        // R2 load, R11 idle ticks
        load_duty(25'd1000);
        one_tick(1);
        one_tick(0);
        check("R11 idle tick no effect", duty_level, 1000);

        // R4 settings write without start
        cfg_wr = 1; cfg_start = 0; cfg_scale = 10'd77; cfg_count = 10'd5; cfg_interval = 10'd1; cfg_up = 1;
        @(negedge clk);
        cfg_wr = 0;
        check("R4 no start flag", start_pending, 0);
        check("R4 not active", ramp_active, 0);
        check("R4 duty kept", duty_level, 1000);
        one_tick(0);

        // R5 up ramp interval 1
        launch(10'd25, 10'd1, 10'd4, 1'b1);
        run_all(1);
        // R5 down ramp interval 3
        launch(10'd40, 10'd3, 10'd2, 1'b0);
        run_all(0);
        // R6 interval 0 acts as 1
        launch(10'd3, 10'd0, 10'd3, 1'b1);
        run_all(0);
        // R8 saturation high
        load_duty(DMAX - 25'd3);
        launch(10'd5, 10'd1, 10'd3, 1'b1);
        run_all(0);
        check("R8 clipped at max", duty_level, DMAX);
        // R8 saturation low
        load_duty(25'd7);
        launch(10'd4, 10'd2, 10'd3, 1'b0);
        run_all(0);
        check("R8 clipped at zero", duty_level, 0);
        // R9 zero count
        load_duty(25'd500);
        launch(10'd9, 10'd1, 10'd0, 1'b1);
        run_all(0);
        check("R9 duty unchanged", duty_level, 500);
        // R10 restart mid-ramp
        load_duty(25'd100);
        launch(10'd10, 10'd1, 10'd5, 1'b1);
        one_tick(0);
        one_tick(0);
        check("R10 before restart", duty_level, 120);
        launch(10'd1, 10'd1, 10'd2, 1'b0);
        run_all(0);
        check("R10 after restart", duty_level, 118);

        // constrained random ramps
        for (int it = 0; it < 20; it++) begin
            load_duty(25'($urandom));
            launch(10'($urandom), 10'($urandom_range(0, 3)), 10'($urandom_range(0, 6)), 1'($urandom));
            run_all(int'($urandom_range(0, 2)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule